// File: doc/BRIEF.md
# Packed Lane-Configurable Saturating Subtractor

This block is one registered stage of a SIMD execution pipe. It subtracts one packed vector from another in every lane, as unsigned integers. A lane whose difference would be negative is forced to zero instead of wrapping. The 32-bit instruction word that comes with each strobe sets how the operands are split into lanes. A 2-bit size field picks 8-, 16-, 32- or 64-bit lanes. A width bit picks a 64-bit or a 128-bit active datapath. An opcode matcher decides whether the strobe is issued at all.

All lane widths share one datapath made of byte slices. The borrow runs from slice to slice inside a lane and is cut at every lane boundary. Each lane is clamped by the borrow out of its own top slice. A sticky status bit records that some active lane clamped. It stays set until the surrounding logic pulses a clear. The block changes no arithmetic condition flags. Its only effects are the result vector and the sticky bit.

Top module: `lane_sat_sub`

## Requirements
- R1: A strobe is issued only when `(insn_i & 32'hBF20FC00) == 32'h2E202C00`. That means bit 31 = 0, bit 29 = 1, bits 28:24 = 01110, bit 21 = 1, bits 15:11 = 00101 and bit 10 = 1. Any other word gives no `valid_o`, and `res_o` and `sat_o` stay unchanged.
- R2: In each active lane where the first element is at least the second, the lane result is first minus second, treating both as unsigned.
- R3: In each active lane where the first element is below the second, the lane result is zero.
- R4: `insn_i[23:22]` selects the lane width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. No borrow crosses a lane boundary.
- R5: `insn_i[30]` = 1 makes all 128 bits active. `insn_i[30]` = 0 computes only bits 63:0 and drives bits 127:64 of the result to zero.
- R6: An issued word with `insn_i[30]` = 0 and `insn_i[23:22]` = 11 is illegal. One cycle later `illegal_o` pulses, `valid_o` stays low, and `res_o` and `sat_o` are unchanged.
- R7: An issued legal strobe gives `valid_o` = 1 on the next clock. The new `res_o` and `rd_o` (equal to `insn_i[4:0]`) appear in that same cycle and are held until the next legal issue.
- R8: `sat_o` becomes 1 one cycle after a legal issue in which any active lane clamps.
- R9: `sat_o` falls only when `sat_clr_i` is high with no clamping issue in the same cycle. When both happen in the same cycle, the set wins.
- R10: When `insn_i[30]` = 0, lanes in bits 127:64 cannot set `sat_o`, whatever the operand values.
- R11: After an asynchronous reset, `valid_o`, `illegal_o`, `sat_o`, `res_o` and `rd_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| insn_i | input | 32 | Instruction word qualifying the strobe |
| opa_i | input | 128 | Minuend vector |
| opb_i | input | 128 | Subtrahend vector |
| sat_clr_i | input | 1 | Synchronous clear of the sticky saturation bit |
| valid_o | output | 1 | Result valid, one cycle after a legal issue |
| illegal_o | output | 1 | Pulse for an issued but illegal width combination |
| res_o | output | 128 | Registered result vector |
| rd_o | output | 5 | Destination field of the issued word |
| sat_o | output | 1 | Sticky saturation status |

## Verification
The random stimulus has three kinds of operand pairs, and each one separates a different fault. Fully random pairs mix clamped and unclamped lanes and exercise the borrow cut at lane edges. Equal pairs must give zeros with no saturation, which tells clamping apart from a zero difference. Pairs that differ in a few low bits put a borrow right at lane edges and expose any leak across a lane boundary.

Directed cases cover:
- all-zero minus all-ones at every lane width;
- the half-width mode with saturating garbage in the upper half;
- the illegal width pair;
- words with a single fixed bit flipped;
- a clear pulse on its own, and a clear in the same cycle as a saturating issue, which together fix the priority of the sticky bit.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned SLICE_W    = 8;
  localparam int unsigned NUM_SIZES  = 4;
  localparam int unsigned SIZE_W     = 2;
  localparam logic [31:0] INSN_MASK  = 32'hBF20FC00;
  localparam logic [31:0] INSN_MATCH = 32'h2E202C00;
  localparam int unsigned Q_BIT      = 30;
  localparam int unsigned SIZE_LSB   = 22;
  localparam int unsigned RD_LSB     = 0;

  typedef enum logic [SIZE_W-1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } lane_size_e;

  typedef struct packed {
    logic       hit;
    logic       illegal;
    logic       wide;
    lane_size_e size;
    logic [4:0] rd;
  } dec_t;
endpackage

// File: rtl/lss_decode.sv
module lss_decode
  import lss_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.hit     = (insn_i & INSN_MASK) == INSN_MATCH;
    dec_o.wide    = insn_i[Q_BIT];
    dec_o.size    = lane_size_e'(insn_i[SIZE_LSB +: SIZE_W]);
    dec_o.rd      = insn_i[RD_LSB +: 5];
    dec_o.illegal = !insn_i[Q_BIT] && (dec_o.size == SZ_64);
  end
endmodule

// File: rtl/lss_slice.sv
module lss_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         bin_i,
  output logic [W-1:0] d_o,
  output logic         bout_o
);
  logic [W:0] t;
  assign t      = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, bin_i};
  assign d_o    = t[W-1:0];
  assign bout_o = t[W];
endmodule

// File: rtl/lss_lanes.sv
module lss_lanes
  import lss_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lane_size_e        size_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  localparam int unsigned NSL  = DATA_W / SLICE_W;
  localparam int unsigned HALF = NSL / 2;

  logic [NSL-1:0] bout, bin, active, clamp, is_top;
  logic [SLICE_W-1:0] diff [NSL];
  logic [NUM_SIZES-1:0] start_m [NSL];
  logic [NUM_SIZES-1:0] top_m   [NSL];
  logic [NUM_SIZES-1:0] clamp_m [NSL];

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int unsigned SPAN = 1 << k;
      assign start_m[s][k] = (s % SPAN) == 0;
      assign top_m[s][k]   = (s % SPAN) == SPAN - 1;
      assign clamp_m[s][k] = bout[s | (SPAN - 1)];
    end

    if (s == 0) begin : g_first
      assign bin[s] = 1'b0;
    end else begin : g_rest
      assign bin[s] = start_m[s][size_i] ? 1'b0 : bout[s-1];
    end

    lss_slice #(.W(SLICE_W)) u_slice (
      .a_i    (a_i[s*SLICE_W +: SLICE_W]),
      .b_i    (b_i[s*SLICE_W +: SLICE_W]),
      .bin_i  (bin[s]),
      .d_o    (diff[s]),
      .bout_o (bout[s])
    );

    assign active[s] = wide_i || (s < HALF);
    assign clamp[s]  = clamp_m[s][size_i];
    assign is_top[s] = top_m[s][size_i];
    assign res_o[s*SLICE_W +: SLICE_W] =
      (active[s] && !clamp[s]) ? diff[s] : '0;
  end

  // Lane saturates when its top slice borrows out
  assign sat_o = |(active & is_top & bout);
endmodule

// File: rtl/lss_sticky.sv
module lss_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/lane_sat_sub.sv
module lane_sat_sub
  import lss_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              sat_clr_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] res_o,
  output logic [4:0]        rd_o,
  output logic              sat_o
);
  dec_t              dec;
  logic [DATA_W-1:0] lane_res;
  logic              lane_sat;
  logic              accept;

  lss_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  lss_lanes #(.DATA_W(DATA_W)) u_lanes (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .size_i (dec.size),
    .wide_i (dec.wide),
    .res_o  (lane_res),
    .sat_o  (lane_sat)
  );

  assign accept = valid_i && dec.hit && !dec.illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      res_o     <= '0;
      rd_o      <= '0;
    end else begin
      valid_o   <= accept;
      illegal_o <= valid_i && dec.hit && dec.illegal;
      if (accept) begin
        res_o <= lane_res;
        rd_o  <= dec.rd;
      end
    end
  end

  lss_sticky u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept && lane_sat),
    .clr_i  (sat_clr_i),
    .q_o    (sat_o)
  );
endmodule

// File: rtl/lane_sat_sub_chk.sv
module lane_sat_sub_chk
  import lss_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [31:0]       insn_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              sat_clr_i,
  input logic              valid_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] res_o,
  input logic [4:0]        rd_o,
  input logic              sat_o
);
  p_issue_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (($past(insn_i) & INSN_MASK) == INSN_MATCH));

  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(insn_i[Q_BIT])) |-> (res_o[DATA_W-1:DATA_W/2] == '0));

  p_illegal_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !valid_o);

  p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  p_set_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> ($past(valid_i) && valid_o));

  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sat_o) |-> $past(sat_clr_i));
endmodule

bind lane_sat_sub lane_sat_sub_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lane_sat_sub_bench.sv
module lane_sat_sub_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h2E202C00;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  insn_i = '0;
  logic [127:0] opa_i = '0, opb_i = '0;
  logic         sat_clr_i = 1'b0;
  logic         valid_o, illegal_o, sat_o;
  logic [127:0] res_o;
  logic [4:0]   rd_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [127:0] exp_res = '0;
  logic [4:0]   exp_rd = '0;
  logic         exp_sat = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lane_sat_sub u_lane_sat_sub (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [128:0] ref_op(input logic [127:0] a, input logic [127:0] b,
                                          input logic [1:0] sz, input logic wide);
    int ew = 8 << sz;
    int n = (wide ? 128 : 64) / ew;
    logic [127:0] r = '0;
    logic sat = 1'b0;
    logic [63:0] m = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
    for (int i = 0; i < n; i++) begin
      logic [63:0] ea = 64'(a >> (i*ew)) & m;
      logic [63:0] eb = 64'(b >> (i*ew)) & m;
      if (ea < eb) sat = 1'b1;
      else r |= 128'((ea - eb) & m) << (i*ew);
    end
    return {sat, r};
  endfunction

  function automatic logic [31:0] mk(input logic wide, input logic [1:0] sz, input logic [4:0] rd);
    logic [31:0] w = BASE | ($urandom & 32'h001F03E0);
    w[30] = wide; w[23:22] = sz; w[4:0] = rd;
    return w;
  endfunction

  // drive at negedge, check at following negedge (one register stage)
  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                       input logic clr, input string tag);
    logic hit = (w & 32'hBF20FC00) == BASE;
    logic ill = hit && !w[30] && (w[23:22] == 2'b11);
    logic [128:0] r = ref_op(a, b, w[23:22], w[30]);
    valid_i = 1'b1; insn_i = w; opa_i = a; opb_i = b; sat_clr_i = clr;
    if (hit && !ill) begin
      exp_res = r[127:0]; exp_rd = w[4:0];
      exp_sat = r[128] | (exp_sat & ~clr);
    end else begin
      exp_sat = exp_sat & ~clr;
    end
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 1'b0; sat_clr_i = 1'b0;
    chk({tag, " valid R7"}, 128'(valid_o), 128'(hit && !ill));
    chk({tag, " illegal R6"}, 128'(illegal_o), 128'(ill));
    chk({tag, " result R2/R3"}, res_o, exp_res);
    chk({tag, " rd R7"}, 128'(rd_o), 128'(exp_rd));
    chk({tag, " sticky R8"}, 128'(sat_o), 128'(exp_sat));
  endtask

  task automatic clear_only();
    sat_clr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    sat_clr_i = 1'b0; exp_sat = 1'b0;
    chk("clear R9", 128'(sat_o), 128'(0));
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'h5EED1234));
    #(CLK_PERIOD*2 + 2);
    // R11 reset state
    chk("reset valid R11", 128'(valid_o), 0);
    chk("reset illegal R11", 128'(illegal_o), 0);
    chk("reset res R11", res_o, 0);
    chk("reset rd R11", 128'(rd_o), 0);
    chk("reset sat R11", 128'(sat_o), 0);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);

    // R2 R4: no borrow across lanes, each width
    for (int s = 0; s < 4; s++)
      issue(mk(1, 2'(s), 5'(s)), {16{8'h10}}, {16{8'h01}}, 1'b0, "R4 width");
    // R2: equal operands give zero without saturation
    issue(mk(1, 2'b00, 5'd3), {16{8'hA5}}, {16{8'hA5}}, 1'b0, "R2 equal");
    // R3: zero minus all-ones at each width
    for (int s = 0; s < 4; s++) begin
      issue(mk(1, 2'(s), 5'd9), '0, '1, 1'b0, "R3 clamp");
      clear_only();
    end
    // R4: borrow stops at lane edge: low byte borrows, lane above must not
    issue(mk(1, 2'b00, 5'd1), 128'h0200, 128'h0001_0001, 1'b0, "R4 edge8");
    issue(mk(1, 2'b01, 5'd1), 128'h0000_0200, 128'h0001_0001, 1'b0, "R4 edge16");
    clear_only();
    // R5 R10: half width, saturating garbage in upper half
    issue(mk(0, 2'b10, 5'd7), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, 1'b0, "R10 upper");
    chk("R10 upper ignored", 128'(sat_o), 0);
    // R6: illegal pair leaves state untouched
    issue(mk(0, 2'b11, 5'd4), '0, '1, 1'b0, "R6 illegal");
    // R1: flip each fixed bit
    foreach (BASE[i]) if (32'hBF20FC00 & (32'd1 << i))
      issue(mk(1, 2'b00, 5'd2) ^ (32'd1 << i), '0, '1, 1'b0, "R1 nomatch");
    // R9: set wins over clear in same cycle, then clear alone
    issue(mk(1, 2'b01, 5'd5), '0, '1, 1'b1, "R9 setwins");
    chk("R9 set priority", 128'(sat_o), 1);
    clear_only();
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [127:0] a = r128(), b;
      int mode = $urandom_range(0, 2);
      b = (mode == 0) ? r128() : (mode == 1) ? a : (a ^ 128'($urandom_range(0, 7)));
      issue(mk(1'($urandom), 2'($urandom), 5'($urandom)), a, b,
            1'($urandom_range(0, 9) == 0), "rand");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R7: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule